// File: doc/BRIEF.md
# Flow-Hashed Receive Channel Dispatcher

This block sits behind the receive frame checker of a multi-channel Ethernet controller. For every validated frame it is given the remote IPv4 address and the remote port already extracted from the headers. It folds them into a small flow key by adding their bytes, reduces the key modulo the channel count chosen at run time, and steers the frame to that channel. Each channel owns two receive container slots. The dispatcher writes the frame into the first free slot of the selected channel, or drops the frame when both slots are occupied.

The modulo is computed by a shift-and-subtract remainder loop, with one bit of the key handled per clock, so no divider is built. The block is busy while the loop runs, and it raises a one-cycle result strobe when the channel decision is made. Three counters record the frames taken in, the frames marked broadcast and the frames dropped because their channel was full. A one-cycle clear strobe sets all three counters to zero.

Top module: `flow_dispatch`

## Requirements
- R1: The flow key is the unsigned sum of the four bytes of `rem_addr` and the two bytes of `rem_port`. Its largest value is 1530.
- R2: The chosen channel `ch_idx` is the flow key modulo N. N is `num_ch` as sampled with the accepted start. A value of 0 is treated as 1, and a value above MAX_CH is treated as MAX_CH.
- R3: `res_valid` is high for exactly one cycle. It rises 12 clock edges after the edge that accepts `frm_start`, which is one edge per key bit plus one. `busy` is high from the accepting edge until the result edge.
- R4: `slot_full` bit 2c is slot 0 of channel c and bit 2c+1 is slot 1. Slot 0 is preferred when it is free. A frame with a free slot gives `wr_en` high together with `res_valid`, and `ch_idx` and `slot_idx` name the channel and slot. The flags are sampled at the result edge.
- R5: When both slots of the chosen channel are full, `drop` pulses with `res_valid`. In that case `wr_en` stays low and `cnt_full` increases by one at the same edge.
- R6: `cnt_rx` increases by one at every edge that accepts a `frm_start`.
- R7: `cnt_bcast` increases by one at an accepting edge where `is_bcast` is high.
- R8: A `frm_start` that arrives while `busy` is high is ignored. It is not counted, and it does not alter the result of the frame in progress.
- R9: `cnt_clr` zeroes all three counters at the next edge. It takes precedence over any increment at that same edge.
- R10: After reset `busy`, `res_valid`, `wr_en`, `drop` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | One-cycle counter clear strobe |
| num_ch | input | 4 | Run-time channel count |
| frm_start | input | 1 | Validated frame start strobe |
| rem_addr | input | 32 | Remote IPv4 address of the frame |
| rem_port | input | 16 | Remote port of the frame |
| is_bcast | input | 1 | Frame is a broadcast |
| slot_full | input | 16 | Occupancy of the two slots of every channel |
| busy | output | 1 | Remainder loop in progress |
| res_valid | output | 1 | Channel decision strobe |
| wr_en | output | 1 | Frame accepted into a slot |
| drop | output | 1 | Frame discarded, channel full |
| ch_idx | output | 3 | Selected channel |
| slot_idx | output | 1 | Selected slot within the channel |
| cnt_rx | output | 32 | Frames taken in |
| cnt_bcast | output | 32 | Broadcast frames taken in |
| cnt_full | output | 32 | Frames dropped on a full channel |

## Verification
A corrupted remainder register or step counter shows up as a wrong `ch_idx`, or as a result strobe that arrives on the wrong cycle. Either is visible 12 edges after the start, and the bench compares both on every frame. A wrong slot decision shows at the same strobe on `slot_idx`, `wr_en` or `drop`, and also in `cnt_full`. A counter that slips, or a start that is wrongly accepted while busy, shows in the counters one edge after the start. These cases are checked with random address, port, count and occupancy mixes, together with directed extremes: the largest key, counts of 0, 1 and above the maximum, a clear at the same edge as a start, and a start during busy.

// File: rtl/flow_disp_pkg.sv
package flow_disp_pkg;

    // widest key: six bytes of 255 each
    localparam int KEY_MAX = 6 * 255;
    localparam int KEY_W   = $clog2(KEY_MAX + 1);

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_S0   = 2'd1,
        PICK_S1   = 2'd2
    } pick_e;

endpackage

// File: rtl/flow_key_sum.sv
module flow_key_sum
    import flow_disp_pkg::*;
(
    input  logic [31:0]      addr,
    input  logic [15:0]      port,
    output logic [KEY_W-1:0] key
);
    localparam int NB = 6;

    logic [8*NB-1:0]  bytes_w;
    logic [KEY_W-1:0] part [0:NB];

    assign bytes_w = {port, addr};
    assign part[0] = '0;

    for (genvar i = 0; i < NB; i++) begin : g_acc
        assign part[i+1] = part[i] + KEY_W'(bytes_w[8*i +: 8]);
    end

    assign key = part[NB];
endmodule

// File: rtl/flow_mod_seq.sv
module flow_mod_seq
    import flow_disp_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             done,
    output logic [CH_W-1:0]  rem
);
    localparam int STEP_W = $clog2(KEY_W);
    localparam int TW     = KEY_W + DIV_W;

    typedef struct packed {
        logic              run;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [KEY_W-1:0]  rem;
        logic [DIV_W-1:0]  div;
    } st_t;

    st_t st_d, st_q;
    logic [TW-1:0] trial;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = TW'(st_q.div) << st_q.step;
        if (start && !st_q.run) begin
            st_d.run  = 1'b1;
            st_d.step = STEP_W'(KEY_W - 1);
            st_d.rem  = key;
            st_d.div  = div;
        end else if (st_q.run) begin
            if (TW'(st_q.rem) >= trial) begin
                st_d.rem = st_q.rem - KEY_W'(trial);
            end
            if (st_q.step == '0) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.run;
    assign done = st_q.done;
    assign rem  = CH_W'(st_q.rem);

    // R2
    rem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.rem < KEY_W'(st_q.div)));

    // R2
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.run) |-> (div != '0));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
endmodule

// File: rtl/flow_slot_pick.sv
module flow_slot_pick
    import flow_disp_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic [CH_W-1:0]     ch,
    input  logic [2*MAX_CH-1:0] slot_full,
    output pick_e               pick
);
    logic s0_full, s1_full;

    assign s0_full = slot_full[{ch, 1'b0}];
    assign s1_full = slot_full[{ch, 1'b1}];

    always_comb begin
        if (!s0_full)      pick = PICK_S0;
        else if (!s1_full) pick = PICK_S1;
        else               pick = PICK_NONE;
    end
endmodule

// File: rtl/flow_counters.sv
module flow_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_rx,
    input  logic             inc_bc,
    input  logic             inc_full,
    output logic [CNT_W-1:0] cnt_rx,
    output logic [CNT_W-1:0] cnt_bc,
    output logic [CNT_W-1:0] cnt_full
);
    typedef struct packed {
        logic [CNT_W-1:0] rx;
        logic [CNT_W-1:0] bc;
        logic [CNT_W-1:0] full;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else begin
            if (inc_rx)   c_d.rx   = c_q.rx + 1'b1;
            if (inc_bc)   c_d.bc   = c_q.bc + 1'b1;
            if (inc_full) c_d.full = c_q.full + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_rx   = c_q.rx;
    assign cnt_bc   = c_q.bc;
    assign cnt_full = c_q.full;

    // R9
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (c_q.rx == '0 && c_q.bc == '0 && c_q.full == '0));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc_full) |=> $stable(c_q.full));
endmodule

// File: rtl/flow_dispatch.sv
module flow_dispatch
    import flow_disp_pkg::*;
#(
    parameter int MAX_CH = 8,
    parameter int CNT_W  = 32,
    localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
    localparam int NUM_W = $clog2(MAX_CH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_clr,
    input  logic [NUM_W-1:0]    num_ch,
    input  logic                frm_start,
    input  logic [31:0]         rem_addr,
    input  logic [15:0]         rem_port,
    input  logic                is_bcast,
    input  logic [2*MAX_CH-1:0] slot_full,
    output logic                busy,
    output logic                res_valid,
    output logic                wr_en,
    output logic                drop,
    output logic [CH_W-1:0]     ch_idx,
    output logic                slot_idx,
    output logic [CNT_W-1:0]    cnt_rx,
    output logic [CNT_W-1:0]    cnt_bcast,
    output logic [CNT_W-1:0]    cnt_full
);
    typedef struct packed {
        logic            valid;
        logic            wr;
        logic            drop;
        logic [CH_W-1:0] ch;
        logic            slot;
    } res_t;

    res_t r_d, r_q;

    logic [KEY_W-1:0] key;
    logic [NUM_W-1:0] n_eff;
    logic             mod_busy, mod_done, accept;
    logic [CH_W-1:0]  rem;
    pick_e            pick;

    assign accept = frm_start && !mod_busy;

    always_comb begin
        if (num_ch == '0)                     n_eff = NUM_W'(1);
        else if (num_ch > NUM_W'(MAX_CH))     n_eff = NUM_W'(MAX_CH);
        else                                  n_eff = num_ch;
    end

    flow_key_sum u_key (
        .addr (rem_addr),
        .port (rem_port),
        .key  (key)
    );

    flow_mod_seq #(.DIV_W(NUM_W), .CH_W(CH_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .key   (key),
        .div   (n_eff),
        .busy  (mod_busy),
        .done  (mod_done),
        .rem   (rem)
    );

    flow_slot_pick #(.MAX_CH(MAX_CH), .CH_W(CH_W)) u_pick (
        .ch        (rem),
        .slot_full (slot_full),
        .pick      (pick)
    );

    flow_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc_rx   (accept),
        .inc_bc   (accept && is_bcast),
        .inc_full (mod_done && pick == PICK_NONE),
        .cnt_rx   (cnt_rx),
        .cnt_bc   (cnt_bcast),
        .cnt_full (cnt_full)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = mod_done;
        r_d.wr    = mod_done && (pick != PICK_NONE);
        r_d.drop  = mod_done && (pick == PICK_NONE);
        if (mod_done) begin
            r_d.ch   = rem;
            r_d.slot = (pick == PICK_S1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = mod_busy;
    assign res_valid = r_q.valid;
    assign wr_en     = r_q.wr;
    assign drop      = r_q.drop;
    assign ch_idx    = r_q.ch;
    assign slot_idx  = r_q.slot;

    // R4
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (wr_en ^ drop));

    // R4
    no_stray_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!wr_en && !drop));

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && mod_busy && !cnt_clr) |=> $stable(cnt_rx));
endmodule

// File: tb/sim_flow_dispatch.sv
module sim_flow_dispatch;
    localparam int MAX_CH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clr = 1'b0;
    logic [3:0]  num_ch = 4'd1;
    logic        frm_start = 1'b0;
    logic [31:0] rem_addr = '0;
    logic [15:0] rem_port = '0;
    logic        is_bcast = 1'b0;
    logic [15:0] slot_full = '0;
    logic        busy, res_valid, wr_en, drop, slot_idx;
    logic [2:0]  ch_idx;
    logic [31:0] cnt_rx, cnt_bcast, cnt_full;

    int n_chk = 0;
    int n_bad = 0;
    int m_rx = 0, m_bc = 0, m_full = 0;

    always #4 clk = ~clk;

    flow_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .num_ch(num_ch),
        .frm_start(frm_start), .rem_addr(rem_addr), .rem_port(rem_port),
        .is_bcast(is_bcast), .slot_full(slot_full), .busy(busy),
        .res_valid(res_valid), .wr_en(wr_en), .drop(drop), .ch_idx(ch_idx),
        .slot_idx(slot_idx), .cnt_rx(cnt_rx), .cnt_bcast(cnt_bcast),
        .cnt_full(cnt_full)
    );

    function automatic int exp_key(input logic [31:0] a, input logic [15:0] p);
        return int'(a[7:0]) + int'(a[15:8]) + int'(a[23:16]) + int'(a[31:24])
             + int'(p[7:0]) + int'(p[15:8]);
    endfunction

    function automatic int exp_n(input logic [3:0] n);
        if (n == 0) return 1;
        if (int'(n) > MAX_CH) return MAX_CH;
        return int'(n);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check({req, " cnt_rx"}, cnt_rx, m_rx);
        check({req, " cnt_bcast"}, cnt_bcast, m_bc);
        check({req, " cnt_full"}, cnt_full, m_full);
    endtask

    // one frame; clr_too: clear at the start edge; poke: extra start while busy
    task automatic run_frame(input logic [31:0] a, input logic [15:0] p,
                             input logic bc, input logic [3:0] n,
                             input logic [15:0] full, input bit clr_too,
                             input bit poke);
        int ch, s0, s1;
        ch = exp_key(a, p) % exp_n(n);
        s0 = full[2*ch];
        s1 = full[2*ch+1];
        @(negedge clk);
        rem_addr = a; rem_port = p; is_bcast = bc; num_ch = n;
        slot_full = full; frm_start = 1'b1; cnt_clr = clr_too;
        @(negedge clk);
        frm_start = 1'b0; cnt_clr = 1'b0;
        if (clr_too) begin
            m_rx = 0; m_bc = 0; m_full = 0;   // R9 clear wins over increment
        end else begin
            m_rx++;                            // R6
            if (bc) m_bc++;                    // R7
        end
        check("R3 busy after start", busy, 1);
        check_counts("R6/R7/R9 after start");
        if (poke) begin
            rem_addr = ~a; rem_port = ~p; num_ch = 4'd3; is_bcast = 1'b1;
            frm_start = 1'b1;
            @(negedge clk);
            frm_start = 1'b0;
            check_counts("R8 start during busy");
            repeat (10) @(posedge clk);
        end else begin
            repeat (11) @(posedge clk);
        end
        @(negedge clk);
        check("R3 no early result", res_valid, 0);
        @(negedge clk);
        check("R3 res_valid", res_valid, 1);
        check("R2 ch_idx", ch_idx, ch);
        if (s0 == 0 || s1 == 0) begin
            check("R4 wr_en", wr_en, 1);
            check("R4 slot_idx", slot_idx, (s0 == 0) ? 0 : 1);
            check("R5 drop", drop, 0);
        end else begin
            m_full++;
            check("R5 drop", drop, 1);
            check("R5 wr_en", wr_en, 0);
        end
        check_counts("R5 counters at result");
        @(negedge clk);
        check("R3 one-cycle strobe", res_valid, 0);
        check("R3 busy cleared", busy, 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy", busy, 0);
        check("R10 res_valid", res_valid, 0);
        check("R10 wr_en", wr_en, 0);
        check("R10 drop", drop, 0);
        check_counts("R10 reset");
        rst_n = 1'b1;

        // R1 largest key, 1530 mod 7 = 4
        run_frame(32'hFFFF_FFFF, 16'hFFFF, 1'b0, 4'd7, 16'h0000, 0, 0);
        // R2 count 0 treated as 1
        run_frame(32'h1234_5678, 16'h9ABC, 1'b1, 4'd0, 16'h0000, 0, 0);
        // R2 count above max clamps to 8
        run_frame(32'h0A0B_0C0D, 16'h0102, 1'b0, 4'd15, 16'h0000, 0, 0);
        // R4 slot 0 taken, slot 1 used: key 3 mod 4 = 3
        run_frame(32'h0000_0102, 16'h0000, 1'b0, 4'd4, 16'h0040, 0, 0);
        // R5 both slots of channel 3 full
        run_frame(32'h0000_0102, 16'h0000, 1'b1, 4'd4, 16'h00C0, 0, 0);
        // R9 clear at same edge as a start
        run_frame(32'h0000_0001, 16'h0001, 1'b1, 4'd2, 16'h0000, 1, 0);
        // R8 start while busy
        run_frame(32'hC0A8_0001, 16'h1F90, 1'b0, 4'd5, 16'h0000, 0, 1);

        // R9 standalone clear
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        m_rx = 0; m_bc = 0; m_full = 0;
        check_counts("R9 standalone clear");

        for (int i = 0; i < 200; i++) begin
            logic [15:0] f;
            f = 16'($urandom);
            if ((i % 3) == 0) f = f | 16'hAAAA;
            run_frame($urandom, 16'($urandom), 1'($urandom), 4'($urandom_range(0, 9)),
                      f, 0, (i % 17) == 5);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule